// File: doc/BRIEF.md
# Serial Management Register Slave

This block is a two-wire serial management slave for one point-to-point link. It exposes three 8-bit registers to a host. SCL and SDA are sampled on a fast system clock, and each line passes through a synchronizer and a majority-free agreement filter before any edge is detected. A condition detector turns the filtered lines into START, STOP and SCL edge pulses. It also keeps two counters: one for the bus-idle window and one for a clock-low timeout.

A protocol state machine matches the 7-bit device address and takes in a register pointer. It then performs either a single-byte write or, after a repeated START, a single-byte read. SDA is driven only through an open-drain output enable. The register bank holds a routing byte and a control byte, which leave the block as configuration outputs. It also presents a read-only view of four loss-of-signal status inputs. Every register returns to its default whenever the mode selector input changes level.

The states are ST_IDLE, ST_DEV_ADDR, ST_DEV_ACK, ST_REG_ADDR, ST_REG_ACK, ST_WR_DATA, ST_WR_ACK, ST_RD_DATA, ST_RD_ACK and ST_WAIT_STOP. All transitions are taken on a falling SCL edge, except the three overrides listed first:

- A STOP or a clock-low timeout sends any state to ST_IDLE.
- A START or repeated START sends any state to ST_DEV_ADDR.
- ST_DEV_ADDR goes to ST_DEV_ACK on an address hit, or to ST_WAIT_STOP on a miss, once eight bits are in.
- ST_DEV_ACK goes to ST_RD_DATA on a read or to ST_REG_ADDR on a write.
- ST_REG_ADDR goes to ST_REG_ACK, and ST_REG_ACK then goes to ST_WR_DATA.
- ST_WR_DATA goes to ST_WR_ACK, and ST_WR_ACK then goes to ST_WAIT_STOP.
- ST_RD_DATA goes to ST_RD_ACK, and ST_RD_ACK then goes to ST_WAIT_STOP.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave answers only the device address {3'b101, addr_strap[3:0]}, with addr_strap[0] as the address LSB and the R/W bit following it (0 write, 1 read). On a match it pulls SDA low during the ninth clock. On a mismatch it leaves SDA released for the rest of the transaction and changes no register.
- R2: In a write (START, address+0, register byte, data byte, STOP), bytes are taken MSB first. The slave acknowledges each of the three bytes with a 0 and stores the data byte into the addressed register.
- R3: In a read (START, address+0, register byte, repeated START, address+1), the slave acknowledges all three bytes. It then shifts out the register contents MSB first and releases SDA once the byte is done.
- R4: Register 0x00 (routing) resets to 0x00, is fully writable and readable, and drives route_cfg.
- R5: Register 0x03 (control) resets to 0x0F. All eight of its bits are writable and readable, and it drives ctrl_cfg.
- R6: Register 0x04 (status) reads as {4'b0000, los_status}. A write to it is acknowledged but changes nothing.
- R7: A write to any other register address is acknowledged and ignored. A read of any other register address returns 0x00.
- R8: Any level change on mode_sel, rising or falling, returns route_cfg to 0x00 and ctrl_cfg to 0x0F.
- R9: sda_oe changes only while SCL is low. It is high only to acknowledge or to send a 0 data bit.
- R10: When SCL stays low for TOUT_CYCLES system clocks, the transaction is abandoned and SDA is released. Bus activity that follows has no effect until a new START.
- R11: bus_idle rises after SCL and SDA have both been high for BUF_CYCLES system clocks. It falls within one cycle of either filtered line going low.
- R12: A STOP that arrives before the data byte of a write is complete abandons the write, and the target register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Mode selector; any level change restores register defaults |
| addr_strap | input | 4 | Low four bits of the device address |
| los_status | input | 4 | Loss-of-signal status, one bit per input channel |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| bus_idle | output | 1 | Bus has been free for the idle window |
| route_cfg | output | 8 | Routing register contents |
| ctrl_cfg | output | 8 | Control register contents |

## Verification
The bench targets the cases where a slave most often goes wrong.

- Address matching is checked under two strap patterns, including the address that was valid before the straps changed. A slave that ignored the straps would acknowledge the stale address or corrupt the routing byte.
- Writes to the status register and to an unmapped address are checked at the configuration outputs and by reading back. A decoder that was too loose would overwrite the control byte, and a read mux that was wrong would return stale or non-zero data.
- A clock held low in the middle of an acknowledge must release SDA. A STOP in the middle of a data byte must leave the register untouched. A design without the timeout would hold the bus low forever, and one that wrote on a partial byte would corrupt the routing register.
- Both mode selector edges must restore the defaults.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_REG_ADDR,
        ST_REG_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT_STOP
    } smb_state_e;

    // register pointer values decoded by the bank
    localparam logic [BYTE_W-1:0] REG_ROUTE = 8'h00;
    localparam logic [BYTE_W-1:0] REG_CTRL  = 8'h03;
    localparam logic [BYTE_W-1:0] REG_STAT  = 8'h04;

    localparam logic [BYTE_W-1:0] ROUTE_DEFAULT = 8'h00;
    localparam logic [BYTE_W-1:0] CTRL_DEFAULT  = 8'h0F;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_q
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    win_q;

    // the filtered level follows the line only once FILT_LEN samples agree
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            line_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&win_q) begin
                line_q <= 1'b1;
            end else if (~|win_q) begin
                line_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect #(
    parameter int BUF_CYCLES  = 235,
    parameter int TOUT_CYCLES = 1500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_p,
    output logic stop_p,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_idle,
    output logic tout_p
);
    localparam int BUF_W  = $clog2(BUF_CYCLES + 1);
    localparam int TOUT_W = $clog2(TOUT_CYCLES + 1);

    logic              scl_d, sda_d;
    logic [BUF_W-1:0]  hi_cnt;
    logic [TOUT_W-1:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_d;
    assign scl_fall = ~scl_f & scl_d;
    assign start_p  = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_p   = scl_f & scl_d & ~sda_d & sda_f;

    // bus free window: both lines high for BUF_CYCLES
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            bus_idle <= 1'b0;
        end else if (!(scl_f && sda_f)) begin
            hi_cnt   <= '0;
            bus_idle <= 1'b0;
        end else if (hi_cnt == BUF_W'(BUF_CYCLES)) begin
            bus_idle <= 1'b1;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // clock-low timeout: one pulse, then saturate until SCL rises
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            tout_p <= 1'b0;
        end else begin
            tout_p <= 1'b0;
            if (scl_f) begin
                lo_cnt <= '0;
            end else if (lo_cnt != TOUT_W'(TOUT_CYCLES)) begin
                lo_cnt <= lo_cnt + 1'b1;
                if (lo_cnt == TOUT_W'(TOUT_CYCLES - 1)) begin
                    tout_p <= 1'b1;
                end
            end
        end
    end

    assert_idle_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_f || !sda_f) |=> !bus_idle);

    assert_tout_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tout_p |-> !scl_f);
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_pkg::*;
#(
    parameter int LOS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic [LOS_W-1:0]  los_in,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] route_q,
    output logic [BYTE_W-1:0] ctrl_q
);
    logic [2:0] mode_sync;
    logic       mode_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_sync <= '0;
        end else begin
            mode_sync <= {mode_sync[1:0], mode_sel};
        end
    end

    assign mode_chg = mode_sync[2] ^ mode_sync[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= ROUTE_DEFAULT;
            ctrl_q  <= CTRL_DEFAULT;
        end else if (mode_chg) begin
            route_q <= ROUTE_DEFAULT;
            ctrl_q  <= CTRL_DEFAULT;
        end else if (wr_en) begin
            if (wr_addr == REG_ROUTE) begin
                route_q <= wr_data;
            end
            if (wr_addr == REG_CTRL) begin
                ctrl_q <= wr_data;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            REG_ROUTE: rd_data = route_q;
            REG_CTRL:  rd_data = ctrl_q;
            REG_STAT:  rd_data = {{(BYTE_W-LOS_W){1'b0}}, los_in};
            default:   rd_data = '0;
        endcase
    end

    assert_mode_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (route_q == ROUTE_DEFAULT && ctrl_q == CTRL_DEFAULT));

    assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_STAT && !mode_chg) |=> ($stable(route_q) && $stable(ctrl_q)));

    assert_unmapped_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != REG_ROUTE && wr_addr != REG_CTRL && !mode_chg)
            |=> ($stable(route_q) && $stable(ctrl_q)));
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter int         BUF_CYCLES  = 235,
    parameter int         TOUT_CYCLES = 1500000,
    parameter int         FIXED_W     = 3,
    parameter logic [2:0] ADDR_FIXED  = 3'b101,
    parameter int         STRAP_W     = 4,
    parameter int         LOS_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_sel,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [LOS_W-1:0]   los_status,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic               bus_idle,
    output logic [BYTE_W-1:0]  route_cfg,
    output logic [BYTE_W-1:0]  ctrl_cfg
);
    localparam int DEV_W = FIXED_W + STRAP_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [1:0] raw_lines, filt_lines;
    logic       scl_f, sda_f;
    logic       start_p, stop_p, scl_rise, scl_fall, tout_p;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        smb_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_in(raw_lines[g]),
            .line_q (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    smb_cond_detect #(
        .BUF_CYCLES (BUF_CYCLES),
        .TOUT_CYCLES(TOUT_CYCLES)
    ) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_p (start_p),
        .stop_p  (stop_p),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .bus_idle(bus_idle),
        .tout_p  (tout_p)
    );

    smb_state_e        state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] ptr_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              rw_q;
    logic              oe_q;
    logic              wr_en_q;
    logic [BYTE_W-1:0] rd_data;
    logic              byte_done;
    logic              addr_hit;
    logic              rx_state;

    assign byte_done = (bit_cnt_q == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg_q[BYTE_W-1:1] == {ADDR_FIXED, addr_strap});
    assign rx_state  = (state_q == ST_DEV_ADDR) || (state_q == ST_REG_ADDR) ||
                       (state_q == ST_WR_DATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (tout_p || stop_p) begin
            state_d = ST_IDLE;
        end else if (start_p) begin
            state_d = ST_DEV_ADDR;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_DEV_ADDR: if (byte_done) state_d = addr_hit ? ST_DEV_ACK : ST_WAIT_STOP;
                ST_DEV_ACK:  state_d = rw_q ? ST_RD_DATA : ST_REG_ADDR;
                ST_REG_ADDR: if (byte_done) state_d = ST_REG_ACK;
                ST_REG_ACK:  state_d = ST_WR_DATA;
                ST_WR_DATA:  if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   state_d = ST_WAIT_STOP;
                ST_RD_DATA:  if (byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:   state_d = ST_WAIT_STOP;
                default:     state_d = state_q;
            endcase
        end
    end

    // datapath and pad output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            ptr_q     <= '0;
            bit_cnt_q <= '0;
            rw_q      <= 1'b0;
            oe_q      <= 1'b0;
            wr_en_q   <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            if (tout_p || stop_p || start_p) begin
                oe_q      <= 1'b0;
                bit_cnt_q <= '0;
            end else begin
                if (scl_rise && !byte_done) begin
                    if (rx_state) begin
                        shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (state_q == ST_RD_DATA) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                if (scl_fall) begin
                    case (state_q)
                        ST_DEV_ADDR: begin
                            if (byte_done) begin
                                rw_q <= shreg_q[0];
                                oe_q <= addr_hit;
                            end
                        end
                        ST_DEV_ACK: begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                shreg_q <= rd_data;
                                oe_q    <= ~rd_data[BYTE_W-1];
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                        ST_REG_ADDR: begin
                            if (byte_done) begin
                                ptr_q <= shreg_q;
                                oe_q  <= 1'b1;
                            end
                        end
                        ST_REG_ACK: begin
                            oe_q      <= 1'b0;
                            bit_cnt_q <= '0;
                        end
                        ST_WR_DATA: begin
                            if (byte_done) begin
                                wr_en_q <= 1'b1;
                                oe_q    <= 1'b1;
                            end
                        end
                        ST_RD_DATA: begin
                            if (byte_done) begin
                                oe_q <= 1'b0;
                            end else begin
                                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                                oe_q    <= ~shreg_q[BYTE_W-2];
                            end
                        end
                        default: oe_q <= 1'b0;
                    endcase
                end
            end
        end
    end

    assign sda_oe = oe_q;

    smb_reg_bank #(
        .LOS_W(LOS_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_sel(mode_sel),
        .wr_en   (wr_en_q),
        .wr_addr (ptr_q),
        .wr_data (shreg_q),
        .rd_addr (ptr_q),
        .los_in  (los_status),
        .rd_data (rd_data),
        .route_q (route_cfg),
        .ctrl_q  (ctrl_cfg)
    );

    assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> !scl_f);

    assert_timeout_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tout_p |=> (state_q == ST_IDLE && !oe_q));

    assert_mismatch_no_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_STOP) |-> !oe_q);

    assert_write_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> (oe_q && state_q == ST_WR_ACK));

    assert_stop_to_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (state_q == ST_IDLE));

    initial begin
        assert_dev_width_R1: assert (DEV_W == BYTE_W - 1);
    end
endmodule

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;
    localparam int BUF_C  = 200;
    localparam int TOUT_C = 2000;
    localparam int Q      = 10;

    logic       clk = 1'b0;
    logic       rst_n, mode_sel;
    logic [3:0] strap, los;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe, bus_idle, sda_line;
    logic [7:0] route, ctrl;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_reg_slave #(
        .BUF_CYCLES (BUF_C),
        .TOUT_CYCLES(TOUT_C)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .addr_strap(strap),
        .los_status(los),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .bus_idle  (bus_idle),
        .route_cfg (route),
        .ctrl_cfg  (ctrl)
    );

    typedef struct {
        string      tag;
        logic [7:0] val;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] obs_q[$];
    int         n_chk  = 0;
    int         n_fail = 0;
    int         r9_bad = 0;
    bit         done   = 1'b0;

    // scoreboard monitor
    initial begin
        logic [7:0] o;
        exp_t       e;
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                o = obs_q.pop_front();
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected item: actual %02h expected none", o);
                end else begin
                    e = exp_q.pop_front();
                    if (o !== e.val) begin
                        n_fail++;
                        $display("FAIL %s: actual %02h expected %02h", e.tag, o, e.val);
                    end
                end
            end
        end
    end

    // R9 watch: the pad enable may only move while SCL is low
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (sda_oe !== prev) && scl_m) r9_bad++;
            prev = sda_oe;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq();
        hq();
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b; hq();
        scl_m = 1'b1; hq();
        s = sda_line; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag, input logic exp_ack);
        logic s;
        exp_q.push_back('{tag, {7'b0, exp_ack}});
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        obs_q.push_back({7'b0, s});
    endtask

    task automatic recv_byte(input logic [7:0] expv, input string tag);
        logic       s;
        logic [7:0] got;
        exp_q.push_back('{tag, expv});
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            got[i] = s;
        end
        clock_bit(1'b1, s);
        obs_q.push_back(got);
    endtask

    task automatic wr_reg(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                          input string tag, input logic hit);
        bus_start();
        send_byte({dev, 1'b0}, tag, !hit);
        send_byte(ra, tag, !hit);
        send_byte(d, tag, !hit);
        bus_stop();
    endtask

    task automatic rd_reg(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] expv,
                          input string tag);
        bus_start();
        send_byte({dev, 1'b0}, tag, 1'b0);
        send_byte(ra, tag, 1'b0);
        bus_start();
        send_byte({dev, 1'b1}, tag, 1'b0);
        recv_byte(expv, tag);
        bus_stop();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic s;
        rst_n = 1'b0; mode_sel = 1'b0; strap = 4'b0110; los = 4'b0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 reset route", route, 8'h00);
        chk("R5 reset ctrl", ctrl, 8'h0F);
        chk("R9 released after reset", {7'b0, sda_oe}, 8'h00);
        chk("R11 not idle yet", {7'b0, bus_idle}, 8'h00);
        repeat (BUF_C + 20) @(negedge clk);
        chk("R11 idle after window", {7'b0, bus_idle}, 8'h01);

        // address 1010110
        wr_reg(7'h56, 8'h00, 8'hA5, "R2 write route", 1'b1);
        chk("R4 route after write", route, 8'hA5);
        rd_reg(7'h56, 8'h00, 8'hA5, "R3 read route");
        wr_reg(7'h56, 8'h03, 8'h35, "R5 write ctrl", 1'b1);
        chk("R5 ctrl after write", ctrl, 8'h35);
        rd_reg(7'h56, 8'h03, 8'h35, "R5 read ctrl");

        los = 4'b1010;
        rd_reg(7'h56, 8'h04, 8'h0A, "R6 read status");
        wr_reg(7'h56, 8'h04, 8'hFF, "R6 status write acked", 1'b1);
        chk("R6 route untouched", route, 8'hA5);
        chk("R6 ctrl untouched", ctrl, 8'h35);
        rd_reg(7'h56, 8'h04, 8'h0A, "R6 status after write");

        wr_reg(7'h56, 8'h07, 8'h3C, "R7 unmapped write acked", 1'b1);
        chk("R7 route untouched", route, 8'hA5);
        chk("R7 ctrl untouched", ctrl, 8'h35);
        rd_reg(7'h56, 8'h07, 8'h00, "R7 unmapped read");
        rd_reg(7'h56, 8'h01, 8'h00, "R7 unmapped read 01");

        wr_reg(7'h57, 8'h00, 8'h11, "R1 mismatch nack", 1'b0);
        chk("R1 route after mismatch", route, 8'hA5);
        strap = 4'b1001;
        repeat (10) @(negedge clk);
        wr_reg(7'h59, 8'h00, 8'h3C, "R1 strap 1001 write", 1'b1);
        chk("R1 route via new strap", route, 8'h3C);
        wr_reg(7'h56, 8'h00, 8'h99, "R1 stale address nack", 1'b0);
        chk("R1 route after stale address", route, 8'h3C);

        mode_sel = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 route default after rise", route, 8'h00);
        chk("R8 ctrl default after rise", ctrl, 8'h0F);
        wr_reg(7'h59, 8'h03, 8'hC0, "R8 write ctrl", 1'b1);
        chk("R8 ctrl before fall", ctrl, 8'hC0);
        mode_sel = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 ctrl default after fall", ctrl, 8'h0F);

        // R12: STOP during the data byte
        wr_reg(7'h59, 8'h00, 8'h42, "R12 setup write", 1'b1);
        bus_start();
        send_byte({7'h59, 1'b0}, "R12 addr", 1'b0);
        send_byte(8'h00, "R12 reg", 1'b0);
        for (int i = 0; i < 4; i++) clock_bit(1'b1, s);
        bus_stop();
        chk("R12 route after partial byte", route, 8'h42);

        // R10: SCL held low while the slave drives an ACK
        bus_start();
        send_byte({7'h59, 1'b0}, "R10 addr", 1'b0);
        for (int i = 0; i < 8; i++) clock_bit(1'b0, s);
        hq();
        chk("R2 ack driven before timeout", {7'b0, sda_oe}, 8'h01);
        repeat (TOUT_C + 100) @(negedge clk);
        chk("R10 released after timeout", {7'b0, sda_oe}, 8'h00);
        clock_bit(1'b1, s);
        send_byte(8'h77, "R10 ignored after abort", 1'b1);
        bus_stop();
        chk("R10 route unchanged", route, 8'h42);

        // R11 around STOP and START
        chk("R11 busy right after stop", {7'b0, bus_idle}, 8'h00);
        repeat (BUF_C + 20) @(negedge clk);
        chk("R11 idle after stop window", {7'b0, bus_idle}, 8'h01);
        sda_m = 1'b0;
        hq();
        chk("R11 drops on start", {7'b0, bus_idle}, 8'h00);
        scl_m = 1'b0; hq();
        bus_stop();

        repeat (5) @(negedge clk);
        chk("R9 sda_oe moves only with SCL low", r9_bad[7:0], 8'h00);
        chk("scoreboard drained", exp_q.size() == 0 ? 8'h00 : 8'h01, 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule